// File: doc/BRIEF.md
# Clock Output Power-Management Controller

This block is the control logic of a clock generator with two differential output pairs and one single-ended reference output. It captures two board straps once, on the first rising edge of a combined power-good and power-down input. One strap picks the device's bus address. The other is a three-level strap that picks the spread-spectrum depth. After that capture, the same input switches the device between power-down and normal operation, and the straps are never sampled again.

For each differential pair the block computes an enable that is driven to the output stage. A pair runs only when all of these hold: power is good, the PLL reports lock, the pair's register enable bit is set, and its active-low enable pin is asserted. Otherwise both legs of the pair are held low. An enable change is applied only during the low phase of the source clock, so a pair never produces a shortened pulse. The reference output has a separate output-enable. It stays high-impedance until power first becomes good. From then on it is driven: it copies the crystal clock while power is good and is driven low during power-down.

The power-good input and the enable pins are asynchronous. Each of them passes through two flops before any edge detection or gating uses it.

Top module: `clkout_pm_ctrl`

## Requirements
- R1: The straps are captured only on the first synchronized low-to-high transition of `pg_pd_n` after reset. Later transitions leave `smb_addr` and `spread_code` unchanged, even if the straps have since changed. `straps_valid` rises at that capture.
- R2: A captured `sadr_strap` of 0 gives `smb_addr` = 7'b1101000, and a value of 1 gives 7'b1101010. The read/write bit is appended below bit 0 outside this block. Before the capture, `smb_addr` reads 7'b1101000.
- R3: The strap `ss_strap` decodes to `spread_code` as follows: 2'b00 (low level) gives 2'b00 (no spread), 2'b01 (mid level) gives 2'b01 (-0.25%), and 2'b10 (high level) gives 2'b10 (-0.5%). The unused value 2'b11 is treated as high and gives 2'b10.
- R4: While the synchronized `pg_pd_n` is low, `dif_t` and `dif_c` are 0 for every pair. This takes effect no later than three clock edges after `pg_pd_n` falls.
- R5: `ref_oe` is 0 from reset until the first synchronized rise of `pg_pd_n`, and stays 1 after that. While `ref_oe` is 1, `ref_out` equals `xtal_in` when power is good and is 0 in power-down.
- R6: Pair i runs when power is good, `pll_lock` is 1, register enable bit i is 1 and `oe_n[i]` is 0. A running pair has `dif_t[i]` = `src_clk` and `dif_c[i]` = ~`src_clk`.
- R7: When power is good but register enable bit i is 0 or `oe_n[i]` is 1, both `dif_t[i]` and `dif_c[i]` are 0.
- R8: No pair starts while `pll_lock` is 0. After a power-down, a new rise of `pg_pd_n` keeps the pairs blocked until `pll_lock` is 1 again, and the straps are not re-captured.
- R9: Every register enable bit resets to 1. A cycle with `en_wr` = 1 loads `en_wdata` into the register enable bits.
- R10: Outside power-down, a pair's enable changes only on a clock edge where `src_clk` is low. As a result, within one high phase of `src_clk`, `dif_t[i]` never changes.
- R11: `pg_pd_n` and `oe_n` pass through two synchronizing flops. A fall of `pg_pd_n` is not yet visible at `ref_out` after one clock edge, and is visible after two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pg_pd_n | input | 1 | Power good (high) / power down (low), asynchronous |
| sadr_strap | input | 1 | Address-select strap |
| ss_strap | input | 2 | Spread strap level: 00 low, 01 mid, 10 high |
| oe_n | input | NUM_DIF | Active-low enable pin for each pair, asynchronous |
| pll_lock | input | 1 | PLL lock flag |
| en_wr | input | 1 | Write strobe for the register enable bits |
| en_wdata | input | NUM_DIF | Value loaded into the register enable bits |
| src_clk | input | 1 | PLL clock that is gated onto the pairs |
| xtal_in | input | 1 | Crystal clock copied to the reference output |
| dif_t | output | NUM_DIF | True leg of each pair |
| dif_c | output | NUM_DIF | Complement leg of each pair |
| ref_out | output | 1 | Reference output data |
| ref_oe | output | 1 | Reference output driver enable (0 = high-impedance) |
| straps_valid | output | 1 | Straps have been captured |
| smb_addr | output | 7 | Selected 7-bit bus address |
| spread_code | output | 2 | Spread depth: 00 off, 01 -0.25%, 10 -0.5% |

## Verification
The assertions check the following on every cycle:
- The captured address and spread code never move once captured.
- The address is always one of the two legal values.
- The pairs are silent one edge into power-down.
- No enable rises without lock.
- No enable changes during a high `src_clk` phase unless the block is in power-down.
- The reference enable never falls.

Other behaviours can only be shown by the bench's scenarios:
- The mapping from each strap value to its outputs.
- The running-versus-held decision for mixes of pins, register bits and lock.
- Re-locking after a power-down.
- The reset value of the register bits.
- The exact two-flop latency on `pg_pd_n`.

// File: rtl/clkout_pm_ctrl.sv
module clkout_pm_ctrl #(
  parameter int          NUM_DIF   = 2,
  parameter logic [6:0]  ADDR_LOW  = 7'b1101000,
  parameter logic [6:0]  ADDR_HIGH = 7'b1101010
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pg_pd_n,
  input  logic               sadr_strap,
  input  logic [1:0]         ss_strap,
  input  logic [NUM_DIF-1:0] oe_n,
  input  logic               pll_lock,
  input  logic               en_wr,
  input  logic [NUM_DIF-1:0] en_wdata,
  input  logic               src_clk,
  input  logic               xtal_in,
  output logic [NUM_DIF-1:0] dif_t,
  output logic [NUM_DIF-1:0] dif_c,
  output logic               ref_out,
  output logic               ref_oe,
  output logic               straps_valid,
  output logic [6:0]         smb_addr,
  output logic [1:0]         spread_code
);

  localparam logic [1:0] SPREAD_OFF  = 2'b00;
  localparam logic [1:0] SPREAD_HALF = 2'b01;
  localparam logic [1:0] SPREAD_FULL = 2'b10;

  logic               pg_m, pg_s, pg_d, started;
  logic [NUM_DIF-1:0] oe_m, oe_s, reg_en, en_q, want;

  function automatic logic [1:0] decode_spread(input logic [1:0] lvl);
    case (lvl)
      2'b00:   return SPREAD_OFF;
      2'b01:   return SPREAD_HALF;
      default: return SPREAD_FULL;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_m <= 1'b0;
      pg_s <= 1'b0;
      pg_d <= 1'b0;
      oe_m <= '1;
      oe_s <= '1;
    end else begin
      pg_m <= pg_pd_n;
      pg_s <= pg_m;
      pg_d <= pg_s;
      oe_m <= oe_n;
      oe_s <= oe_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started     <= 1'b0;
      smb_addr    <= ADDR_LOW;
      spread_code <= SPREAD_OFF;
    end else if (pg_s && !pg_d && !started) begin
      started     <= 1'b1;
      smb_addr    <= sadr_strap ? ADDR_HIGH : ADDR_LOW;
      spread_code <= decode_spread(ss_strap);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_en <= '1;
    else if (en_wr)  reg_en <= en_wdata;
  end

  assign want = {NUM_DIF{pg_s & pll_lock}} & reg_en & ~oe_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        en_q <= '0;
    else if (!pg_s)    en_q <= '0;
    else if (!src_clk) en_q <= want;
  end

  assign dif_t        = en_q & {NUM_DIF{src_clk}};
  assign dif_c        = en_q & {NUM_DIF{~src_clk}};
  assign ref_oe       = started;
  assign ref_out      = started & pg_s & xtal_in;
  assign straps_valid = started;

  AST_STRAPS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(started) |-> ($stable(smb_addr) && $stable(spread_code))); // R1

  AST_ADDR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (smb_addr == ADDR_LOW) || (smb_addr == ADDR_HIGH)); // R2

  AST_PD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_s |=> (dif_t == '0 && dif_c == '0)); // R4

  AST_REF_STAYS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(ref_oe)); // R5

  AST_LOCK_BEFORE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_q & ~$past(en_q)) != '0) |-> $past(pll_lock)); // R8

  AST_NO_RUNT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(src_clk) && $past(pg_s)) |-> (en_q == $past(en_q))); // R10

endmodule

// File: tb/tb_clkout_pm_ctrl.sv
module tb_clkout_pm_ctrl;
  localparam int N = 2;

  logic clk = 0, rst_n = 0, pg_pd_n = 0, sadr_strap = 0, pll_lock = 0;
  logic en_wr = 0, src_clk = 0, xtal_in = 0, xtal_run = 1;
  logic [1:0] ss_strap = 0;
  logic [N-1:0] oe_n = '1, en_wdata = '0;
  logic [N-1:0] dif_t, dif_c;
  logic ref_out, ref_oe, straps_valid;
  logic [6:0] smb_addr;
  logic [1:0] spread_code;

  int total = 0, failed = 0, runt_err = 0;
  bit runt_mon = 0, done = 0;
  logic [N-1:0] b_reg = '1;
  logic prev_src = 0;
  logic [N-1:0] prev_t = '0;
  int ph = 0;

  clkout_pm_ctrl #(.NUM_DIF(N)) dut (
    .clk(clk), .rst_n(rst_n), .pg_pd_n(pg_pd_n), .sadr_strap(sadr_strap),
    .ss_strap(ss_strap), .oe_n(oe_n), .pll_lock(pll_lock), .en_wr(en_wr),
    .en_wdata(en_wdata), .src_clk(src_clk), .xtal_in(xtal_in), .dif_t(dif_t),
    .dif_c(dif_c), .ref_out(ref_out), .ref_oe(ref_oe),
    .straps_valid(straps_valid), .smb_addr(smb_addr), .spread_code(spread_code));

  always #10 clk = ~clk;

  always @(negedge clk) begin
    ph <= ph + 1;
    if (ph % 2 == 1) src_clk <= ~src_clk;
    if (xtal_run && ph % 3 == 0) xtal_in <= ~xtal_in;
  end

  always @(negedge clk) begin
    #6;
    if (runt_mon) begin
      if (src_clk && prev_src && dif_t != prev_t) runt_err++;
      prev_src = src_clk;
      prev_t = dif_t;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] exp_addr(input logic s);
    return s ? 7'b1101010 : 7'b1101000;
  endfunction

  function automatic logic [1:0] exp_spread(input logic [1:0] l);
    return (l == 2'b00) ? 2'b00 : (l == 2'b01) ? 2'b01 : 2'b10;
  endfunction

  function automatic bit exp_run(input logic pg, input logic lk, input logic rg, input logic o);
    return pg && lk && rg && !o;
  endfunction

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic check_pairs(input string req);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #5;
      for (int i = 0; i < N; i++) begin
        bit r = exp_run(pg_pd_n, pll_lock, b_reg[i], oe_n[i]);
        chk(dif_t[i] == (r & src_clk) && dif_c[i] == (r & ~src_clk), req,
            {dif_t[i], dif_c[i]}, {r & src_clk, r & ~src_clk});
      end
    end
  endtask

  task automatic write_reg(input logic [N-1:0] v);
    @(negedge clk);
    en_wr = 1; en_wdata = v;
    @(negedge clk);
    en_wr = 0;
    b_reg = v;
  endtask

  task automatic do_reset(input logic s, input logic [1:0] l);
    @(negedge clk);
    rst_n = 0; pg_pd_n = 0; sadr_strap = s; ss_strap = l; b_reg = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    void'($urandom(32'h5eed));
    do_reset(1'b1, 2'b01);
    settle();
    #5;
    chk(ref_oe == 0, "R5 ref hi-z before power good", ref_oe, 0);
    chk(straps_valid == 0, "R1 no capture before edge", straps_valid, 0);
    chk(smb_addr == 7'b1101000, "R2 address before capture", smb_addr, 7'b1101000);
    chk(dif_t == 0 && dif_c == 0, "R4 pairs low at reset", {dif_t, dif_c}, 0);

    oe_n = '0; pll_lock = 0;
    pg_pd_n = 1;
    settle();
    #5;
    chk(straps_valid == 1, "R1 capture on first edge", straps_valid, 1);
    chk(smb_addr == exp_addr(1), "R2 address strap 1", smb_addr, exp_addr(1));
    chk(spread_code == exp_spread(2'b01), "R3 mid level", spread_code, 2'b01);
    chk(ref_oe == 1, "R5 ref driven after edge", ref_oe, 1);
    check_pairs("R8 blocked without lock");
    pll_lock = 1;
    settle();
    check_pairs("R9 reset enables allow run");

    sadr_strap = 0; ss_strap = 2'b10;
    pg_pd_n = 0; pll_lock = 0;
    settle();
    check_pairs("R4 power down");
    #1;
    chk(ref_oe == 1 && ref_out == 0, "R5 ref low in power down", {ref_oe, ref_out}, 2'b10);
    pg_pd_n = 1;
    settle();
    check_pairs("R8 blocked after exit until lock");
    pll_lock = 1;
    settle();
    check_pairs("R8 runs after relock");
    chk(smb_addr == exp_addr(1) && spread_code == 2'b01, "R1 no recapture",
        {smb_addr, spread_code}, {exp_addr(1), 2'b01});

    xtal_run = 0;
    @(negedge clk); xtal_in = 1;
    repeat (3) @(negedge clk);
    pg_pd_n = 0;
    @(posedge clk); #5;
    chk(ref_out == 1, "R11 one edge not yet visible", ref_out, 1);
    @(posedge clk); #5;
    chk(ref_out == 0, "R11 R5 visible after two edges", ref_out, 0);
    xtal_run = 1;
    pg_pd_n = 1;
    settle();

    write_reg(2'b01);
    settle();
    check_pairs("R7 register disable");
    oe_n = 2'b01;
    settle();
    check_pairs("R7 pin disable");
    write_reg('1); oe_n = '0;
    settle();
    check_pairs("R6 both running");

    for (int it = 0; it < 40; it++) begin
      @(negedge clk);
      pg_pd_n = ($urandom % 4) != 0;
      pll_lock = ($urandom % 4) != 0;
      oe_n = N'($urandom);
      sadr_strap = 1'($urandom);
      ss_strap = 2'($urandom);
      if ($urandom % 2) write_reg(N'($urandom));
      settle();
      check_pairs("R6 R7 random mix");
      #1;
      chk(ref_out == (pg_pd_n & xtal_in), "R5 ref follows crystal", ref_out, pg_pd_n & xtal_in);
      chk(smb_addr == exp_addr(1) && spread_code == 2'b01, "R1 straps frozen",
          {smb_addr, spread_code}, {exp_addr(1), 2'b01});
    end

    pg_pd_n = 1; pll_lock = 1; write_reg('1);
    settle();
    runt_mon = 1;
    for (int it = 0; it < 60; it++) begin
      @(negedge clk);
      if ($urandom % 2) oe_n = N'($urandom);
    end
    runt_mon = 0;
    chk(runt_err == 0, "R10 no change in high phase", runt_err, 0);

    for (int v = 0; v < 4; v++) begin
      do_reset(1'b0, 2'(v));
      pg_pd_n = 1;
      settle();
      #5;
      chk(spread_code == exp_spread(2'(v)), "R3 spread decode", spread_code, exp_spread(2'(v)));
      chk(smb_addr == exp_addr(0), "R2 address strap 0", smb_addr, exp_addr(0));
    end

    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule